// File: doc/BRIEF.md
# USB Host Frame Timing Scheduler

This block keeps the frame clock of a USB host controller and decides which kind of list work may run at each point in a frame. A 14-bit remaining-time counter counts down on every bit-time tick. When it runs out it reloads from a programmable frame length. Each reload is a frame boundary. At a boundary the block advances a 16-bit frame number and pulses start-of-frame. It then asks the memory side to store the new frame number in the shared host area. The list-fetch enable stays off until that store is acknowledged, and the acknowledge also sets a sticky start-of-frame status bit.

Within a frame, the block compares the remaining count with two thresholds. The first is a periodic-start value, loaded by software and cleared by reset. Once the count falls to it, the periodic lists get priority. This waits until any control or bulk transaction already on the wire has finished. The second is a low-speed threshold. It decides whether a short low-speed packet may still start before the frame ends. Turning the controller on (a rising run enable) counts as a frame boundary, so the first frame starts at once.

Top module: `usb_frame_sched`

## Requirements
- R1: `frame_num` is 0 after reset. It rises by one at each frame boundary and rolls from 0xFFFF to 0x0000.
- R2: `remaining` is 0 after reset. While `run_en` is high, each `bit_tick` lowers it by one. A tick that arrives at 0 is a frame boundary, and the boundary loads `frame_ivl`. While `run_en` is low, `remaining` holds its value.
- R3: A rising `run_en` is a frame boundary even without a tick. It reloads `remaining` and advances `frame_num`.
- R4: `sof_pulse` is high for the one cycle after a boundary edge. In that same cycle `hcca_wr_req` rises and `hcca_wr_data` shows the new frame number. The request stays high until `hcca_wr_ack` is sampled.
- R5: `list_fetch_en` is low from the boundary edge until the edge that samples the acknowledge of the pending request. It is high from the next cycle on.
- R6: `sof_status` is set in the cycle after an acknowledged request and is cleared by `sof_clr`. When both occur on the same edge, the set wins.
- R7: The periodic-start register is 0 after reset. It takes `ps_value` on an edge where `ps_load` is high.
- R8: `periodic_prio` rises one edge after a cycle with `run_en` high, `remaining` ≤ periodic start and `ctlblk_busy` low. While `ctlblk_busy` is high it does not rise. Once set, it stays high until the next boundary edge clears it.
- R9: `ls_commit_ok` is high in the same cycle whenever `run_en` is high and `remaining` ≥ `ls_thresh` (zero-extended). Otherwise it is low.
- R10: An acknowledge that arrives while no request is pending is ignored. `sof_status` and `list_fetch_en` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Controller is in the operational state |
| bit_tick | input | 1 | One pulse per bit time |
| frame_ivl | input | 14 | Reload value of the remaining counter |
| ps_load | input | 1 | Load strobe for the periodic-start register |
| ps_value | input | 14 | New periodic-start value |
| ls_thresh | input | 11 | Low-speed commit threshold, held static |
| ctlblk_busy | input | 1 | A control/bulk transaction is in progress |
| hcca_wr_ack | input | 1 | Shared-area write acknowledge |
| sof_clr | input | 1 | Clears the start-of-frame status bit |
| frame_num | output | 16 | Current frame number |
| remaining | output | 14 | Bit times left in the frame |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |
| hcca_wr_req | output | 1 | Request to store the frame number |
| hcca_wr_data | output | 16 | Frame number to store |
| sof_status | output | 1 | Sticky start-of-frame status |
| list_fetch_en | output | 1 | List descriptor fetches allowed |
| periodic_prio | output | 1 | Periodic lists have priority |
| ls_commit_ok | output | 1 | A low-speed packet may start |

## Verification
`frame_num`, `remaining`, `sof_pulse` and `hcca_wr_req` change on the first edge that samples a boundary condition. `sof_status`, the fall of the request and the return of `list_fetch_en` change on the first edge that samples the acknowledge. `periodic_prio` follows one edge after the compare is true with the busy input low. `ls_commit_ok` is combinational and follows `remaining` in the same cycle. The bench drives every input 1 ns after a rising edge and reads the results in that same slot, so each check sees exactly the edge it counted. A negedge monitor pops one expected frame number for every start-of-frame strobe.

// File: rtl/usb_fsched_pkg.sv
// Shared widths and the publish-state type for the frame timing scheduler.
// Assumes the frame counter is never wider than 16 bits.
package usb_fsched_pkg;
    localparam int REM_W_DEF = 14;   // remaining-time counter width
    localparam int FN_W_DEF  = 16;   // frame number width
    localparam int LS_W_DEF  = 11;   // low-speed threshold width

    typedef enum logic [0:0] {
        PUB_IDLE = 1'b0,
        PUB_WAIT = 1'b1
    } pub_state_e;
endpackage

// File: rtl/fsched_timer.sv
// Frame timer: counts bit times down, finds the frame boundary and advances
// the frame number. Assumes bit_tick is at most one pulse per clock cycle and
// frame_ivl is stable while the counter reloads.
module fsched_timer #(
    parameter int REM_W = 14,
    parameter int FN_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             bit_tick,
    input  logic [REM_W-1:0] frame_ivl,
    output logic [REM_W-1:0] remaining,
    output logic [FN_W-1:0]  frame_num,
    output logic             boundary,
    output logic             sof_pulse
);
    localparam logic [REM_W-1:0] REM_ONE = REM_W'(1);
    localparam logic [FN_W-1:0]  FN_ONE  = FN_W'(1);

    logic run_q;
    logic enter_run;
    logic count_out;

    // Boundary detection: turning on, or a tick arriving with the count at zero.
    always_comb begin
        enter_run = run_en & ~run_q;
        count_out = run_en & bit_tick & (remaining == '0);
        boundary  = enter_run | count_out;
    end

    // Remember the previous run enable so a rising edge can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_en;
    end

    // Remaining-time counter: reload at a boundary, otherwise count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                   remaining <= '0;
        else if (boundary)            remaining <= frame_ivl;
        else if (run_en && bit_tick)  remaining <= remaining - REM_ONE;
    end

    // Frame number advance and start-of-frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_num <= '0;
            sof_pulse <= 1'b0;
        end else begin
            sof_pulse <= boundary;
            if (boundary) frame_num <= frame_num + FN_ONE;
        end
    end

    AST_FN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (frame_num == FN_W'($past(frame_num) + FN_ONE)));   // R1
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (remaining == $past(frame_ivl)));                   // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(remaining));                                 // R2
    AST_ENTER_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !run_q) |=> sof_pulse);                               // R3
endmodule

// File: rtl/fsched_publish.sv
// Frame-number publisher: after each boundary it asks for the frame number to
// be stored in the shared host area. It holds list fetches off until the
// store is acknowledged, then sets the sticky start-of-frame status. Assumes
// the acknowledge is a single sample of a held request.
module fsched_publish
    import usb_fsched_pkg::*;
#(
    parameter int FN_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boundary,
    input  logic [FN_W-1:0] frame_num,
    input  logic            wr_ack,
    input  logic            sof_clr,
    output logic            wr_req,
    output logic [FN_W-1:0] wr_data,
    output logic            sof_status,
    output logic            fetch_en
);
    pub_state_e state;
    logic       ack_take;

    // An acknowledge counts only while a request is pending and no new frame starts.
    always_comb begin
        ack_take = (state == PUB_WAIT) & wr_ack & ~boundary;
        wr_req   = (state == PUB_WAIT);
        wr_data  = frame_num;
    end

    // Publish state and fetch gate: a boundary opens a request and shuts fetches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PUB_IDLE;
            fetch_en <= 1'b0;
        end else if (boundary) begin
            state    <= PUB_WAIT;
            fetch_en <= 1'b0;
        end else if (ack_take) begin
            state    <= PUB_IDLE;
            fetch_en <= 1'b1;
        end
    end

    // Sticky status bit: setting takes precedence over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)        sof_status <= 1'b0;
        else if (ack_take) sof_status <= 1'b1;
        else if (sof_clr)  sof_status <= 1'b0;
    end

    AST_NO_FETCH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !fetch_en);                                           // R5
    AST_STATUS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack && !boundary) |=> (sof_status && fetch_en && !wr_req)); // R6
    AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req && !sof_status && !boundary) |=> !sof_status);          // R10
    AST_FETCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req && fetch_en && !boundary) |=> fetch_en);                // R10
endmodule

// File: rtl/fsched_prio.sv
// Priority decisions inside a frame. Periodic work wins once the remaining
// count has fallen to the periodic-start value and no control/bulk
// transaction is in flight. A low-speed packet may start only while enough
// bit times are left. Assumes ls_thresh is static while running.
module fsched_prio #(
    parameter int REM_W = 14,
    parameter int LS_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             boundary,
    input  logic [REM_W-1:0] remaining,
    input  logic             ps_load,
    input  logic [REM_W-1:0] ps_value,
    input  logic             ctlblk_busy,
    input  logic [LS_W-1:0]  ls_thresh,
    output logic             periodic_prio,
    output logic             ls_commit_ok
);
    localparam int CMP_W = (REM_W > LS_W) ? REM_W : LS_W;

    logic [REM_W-1:0] ps_reg;
    logic [CMP_W-1:0] rem_ext;
    logic [CMP_W-1:0] ls_ext;
    logic             ps_reached;

    // Compare the count against both thresholds at a common width.
    always_comb begin
        rem_ext      = CMP_W'(remaining);
        ls_ext       = CMP_W'(ls_thresh);
        ps_reached   = run_en & (remaining <= ps_reg);
        ls_commit_ok = run_en & (rem_ext >= ls_ext);
    end

    // Periodic-start register, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       ps_reg <= '0;
        else if (ps_load) ps_reg <= ps_value;
    end

    // Periodic priority: set once the bus is free, dropped at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                          periodic_prio <= 1'b0;
        else if (boundary)                   periodic_prio <= 1'b0;
        else if (ps_reached && !ctlblk_busy) periodic_prio <= 1'b1;
    end

    AST_PRIO_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periodic_prio) |-> $past(!ctlblk_busy));                   // R8
    AST_PRIO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> !periodic_prio);                                    // R8
    AST_PRIO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (periodic_prio && !boundary) |=> periodic_prio);                 // R8
endmodule

// File: rtl/usb_frame_sched.sv
// Top of the USB host frame timing scheduler. It joins the frame timer, the
// frame-number publisher and the priority logic. Assumes a synchronous
// active-low reset and inputs that are already synchronous to clk.
module usb_frame_sched
    import usb_fsched_pkg::*;
#(
    parameter int REM_W = REM_W_DEF,
    parameter int FN_W  = FN_W_DEF,
    parameter int LS_W  = LS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             bit_tick,
    input  logic [REM_W-1:0] frame_ivl,
    input  logic             ps_load,
    input  logic [REM_W-1:0] ps_value,
    input  logic [LS_W-1:0]  ls_thresh,
    input  logic             ctlblk_busy,
    input  logic             hcca_wr_ack,
    input  logic             sof_clr,
    output logic [FN_W-1:0]  frame_num,
    output logic [REM_W-1:0] remaining,
    output logic             sof_pulse,
    output logic             hcca_wr_req,
    output logic [FN_W-1:0]  hcca_wr_data,
    output logic             sof_status,
    output logic             list_fetch_en,
    output logic             periodic_prio,
    output logic             ls_commit_ok
);
    logic boundary;

    fsched_timer #(.REM_W(REM_W), .FN_W(FN_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .bit_tick  (bit_tick),
        .frame_ivl (frame_ivl),
        .remaining (remaining),
        .frame_num (frame_num),
        .boundary  (boundary),
        .sof_pulse (sof_pulse)
    );

    fsched_publish #(.FN_W(FN_W)) u_publish (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (boundary),
        .frame_num  (frame_num),
        .wr_ack     (hcca_wr_ack),
        .sof_clr    (sof_clr),
        .wr_req     (hcca_wr_req),
        .wr_data    (hcca_wr_data),
        .sof_status (sof_status),
        .fetch_en   (list_fetch_en)
    );

    fsched_prio #(.REM_W(REM_W), .LS_W(LS_W)) u_prio (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en        (run_en),
        .boundary      (boundary),
        .remaining     (remaining),
        .ps_load       (ps_load),
        .ps_value      (ps_value),
        .ctlblk_busy   (ctlblk_busy),
        .ls_thresh     (ls_thresh),
        .periodic_prio (periodic_prio),
        .ls_commit_ok  (ls_commit_ok)
    );

    AST_SOF_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> (hcca_wr_req && !list_fetch_en));                  // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hcca_wr_req && !hcca_wr_ack) |=> hcca_wr_req);                  // R4
endmodule

// File: tb/sim_usb_frame_sched.sv
// Scoreboard bench: expect_frame() queues each frame number the design
// should publish, and a negedge monitor pops one entry per start-of-frame.
module sim_usb_frame_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0, bit_tick = 1'b0;
    logic [13:0] frame_ivl = '0, ps_value = '0;
    logic        ps_load = 1'b0;
    logic [10:0] ls_thresh = '0;
    logic        ctlblk_busy = 1'b0, hcca_wr_ack = 1'b0, sof_clr = 1'b0;
    logic [15:0] frame_num, hcca_wr_data;
    logic [13:0] remaining;
    logic        sof_pulse, hcca_wr_req, sof_status, list_fetch_en;
    logic        periodic_prio, ls_commit_ok;

    int   checks = 0;
    int   errors = 0;
    logic sb_en  = 1'b1;
    logic done   = 1'b0;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    usb_frame_sched u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .bit_tick(bit_tick),
        .frame_ivl(frame_ivl), .ps_load(ps_load), .ps_value(ps_value),
        .ls_thresh(ls_thresh), .ctlblk_busy(ctlblk_busy),
        .hcca_wr_ack(hcca_wr_ack), .sof_clr(sof_clr), .frame_num(frame_num),
        .remaining(remaining), .sof_pulse(sof_pulse), .hcca_wr_req(hcca_wr_req),
        .hcca_wr_data(hcca_wr_data), .sof_status(sof_status),
        .list_fetch_en(list_fetch_en), .periodic_prio(periodic_prio),
        .ls_commit_ok(ls_commit_ok)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Move to 1 ns after the next rising edge.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_frame(input logic [15:0] v);
        exp_q.push_back(v);
    endtask

    // Monitor: every start-of-frame must carry the next queued frame number.
    always @(negedge clk) begin
        if (sb_en && rst_n && sof_pulse) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4 unexpected SOF actual=%0h expected=none", hcca_wr_data);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk("R4 published frame number", hcca_wr_data, e);
                chk("R4 request with SOF", hcca_wr_req, 1);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1 reset frame_num", frame_num, 0);
        chk("R2 reset remaining", remaining, 0);
        chk("R6 reset status", sof_status, 0);
        chk("R5 reset fetch", list_fetch_en, 0);
        chk("R4 reset req", hcca_wr_req, 0);
        chk("R9 idle ls commit", ls_commit_ok, 0);
        chk("R8 reset prio", periodic_prio, 0);

        // R3: turning on starts a frame
        frame_ivl = 14'd5; ls_thresh = 11'd3;
        expect_frame(16'd1);
        run_en = 1'b1;
        cyc();
        chk("R3 enter frame_num", frame_num, 1);
        chk("R3 enter reload", remaining, 5);
        chk("R4 sof pulse", sof_pulse, 1);
        chk("R5 fetch off after boundary", list_fetch_en, 0);
        chk("R7 prio off with zero start", periodic_prio, 0);
        chk("R9 ls ok at 5", ls_commit_ok, 1);
        cyc();
        chk("R4 sof one cycle", sof_pulse, 0);
        cyc(); cyc();
        chk("R4 req held", hcca_wr_req, 1);
        chk("R5 fetch held off", list_fetch_en, 0);

        hcca_wr_ack = 1'b1;
        cyc();
        hcca_wr_ack = 1'b0;
        chk("R4 req dropped on ack", hcca_wr_req, 0);
        chk("R6 status set", sof_status, 1);
        chk("R5 fetch on after ack", list_fetch_en, 1);

        sof_clr = 1'b1;
        cyc();
        sof_clr = 1'b0;
        chk("R6 status cleared", sof_status, 0);

        hcca_wr_ack = 1'b1;
        cyc();
        hcca_wr_ack = 1'b0;
        chk("R10 stray ack status", sof_status, 0);
        chk("R10 stray ack fetch", list_fetch_en, 1);

        // R2 / R9 counting and low-speed threshold
        bit_tick = 1'b1;
        cyc(); cyc();
        chk("R2 count down", remaining, 3);
        chk("R9 ls ok at threshold", ls_commit_ok, 1);
        cyc();
        bit_tick = 1'b0;
        chk("R9 ls blocked below threshold", ls_commit_ok, 0);
        chk("R7 prio off at 2 with zero start", periodic_prio, 0);

        run_en = 1'b0; bit_tick = 1'b1;
        cyc(); cyc();
        chk("R2 hold while stopped", remaining, 2);
        chk("R9 ls off while stopped", ls_commit_ok, 0);

        bit_tick = 1'b0; run_en = 1'b1;
        expect_frame(16'd2);
        cyc();
        chk("R3 re-enter frame_num", frame_num, 2);
        chk("R3 re-enter reload", remaining, 5);
        hcca_wr_ack = 1'b1;
        cyc();
        hcca_wr_ack = 1'b0;

        // R7 / R8 periodic start with busy control/bulk
        ps_value = 14'd1; ps_load = 1'b1;
        cyc();
        ps_load = 1'b0; ctlblk_busy = 1'b1; bit_tick = 1'b1;
        repeat (4) cyc();
        bit_tick = 1'b0;
        chk("R2 count to 1", remaining, 1);
        cyc(); cyc();
        chk("R8 prio waits for busy", periodic_prio, 0);
        ctlblk_busy = 1'b0;
        cyc();
        chk("R8 prio after busy ends", periodic_prio, 1);

        expect_frame(16'd3);
        bit_tick = 1'b1;
        cyc();
        chk("R8 prio kept in frame", periodic_prio, 1);
        cyc();
        bit_tick = 1'b0;
        chk("R1 frame 3", frame_num, 3);
        chk("R2 reload after count out", remaining, 5);
        chk("R8 prio cleared at boundary", periodic_prio, 0);

        // R6 set wins over clear
        sof_clr = 1'b1;
        cyc();
        sof_clr = 1'b0;
        chk("R6 cleared before race", sof_status, 0);
        hcca_wr_ack = 1'b1; sof_clr = 1'b1;
        cyc();
        hcca_wr_ack = 1'b0; sof_clr = 1'b0;
        chk("R6 set beats clear", sof_status, 1);

        // R1 wrap: one boundary per cycle
        sb_en = 1'b0; frame_ivl = '0; bit_tick = 1'b1;
        for (int i = 0; i < 70000; i++) begin
            cyc();
            if (frame_num == 16'hFFFD) break;
        end
        bit_tick = 1'b0;
        chk("R1 reached FFFD", frame_num, 16'hFFFD);
        cyc();
        sb_en = 1'b1;
        expect_frame(16'hFFFE);
        bit_tick = 1'b1;
        cyc();
        bit_tick = 1'b0;
        chk("R1 FFFE", frame_num, 16'hFFFE);
        expect_frame(16'hFFFF);
        bit_tick = 1'b1;
        cyc();
        bit_tick = 1'b0;
        chk("R1 FFFF", frame_num, 16'hFFFF);
        expect_frame(16'h0000);
        bit_tick = 1'b1;
        cyc();
        bit_tick = 1'b0;
        chk("R1 wrap to zero", frame_num, 16'h0000);
        cyc();
        chk("R4 all frames published", exp_q.size(), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule